// File: doc/BRIEF.md
# Dual-Port Semaphore Latch Bank

This block provides a small bank of one-bit hardware semaphores shared by two independent ports, a left one and a right one. Software on each side uses them to agree on the ownership of some shared resource. A port picks a latch with a small index, writes 0 to ask for it and writes 1 to give it up, and then reads the latch back to learn whether it now holds it. A read returns 0 only to the side that currently holds the latch. It returns 1 when the latch is free or when the other side holds it. The status is copied onto every bit of the read bus.

The two sides never share a latch. If both ask for a free latch in the same cycle, the left side gets it. A request made while the other side holds the latch is remembered. It turns into ownership as soon as the holder releases, with no further write needed.

A port reaches semaphore space only while its semaphore select is high and its memory chip enable is low. A write changes the latch at once. The status reported to the writing port refreshes only after a gap, which is a cycle with no semaphore read or write on that port. A read that follows a write with no gap in between returns the previous status.

Top module: `sem_bank`

## Requirements
- R1: After reset every latch is free, both status outputs are all ones, and a read of any index on either port returns all ones.
- R2: A write with data 0 to a free latch gives it to the writer. After a gap, a read of that index by the owner returns all zeros on every bit, and a read by the other port returns all ones.
- R3: A write of 1 by the owner frees the latch when the other side has no pending request, and both ports then read all ones.
- R4: A write of 0 to a latch held by the other side leaves the writer reading all ones. The request is kept pending and is granted to the writer in the cycle the owner writes 1, with no further access by the writer.
- R5: When both ports write 0 to the same free latch in the same cycle, the left port becomes owner and the right request stays pending.
- R6: The latches behave independently. Claiming or releasing one index changes the status read at no other index, on either port.
- R7: A port whose memory chip enable is high, or whose select is low, makes no semaphore access. Its writes leave latch ownership unchanged and its reads leave its status output unchanged.
- R8: A read cycle that follows a write on the same port, with no gap between them, leaves that port's status output at its previous value. The status keeps this value until a cycle with select low, or with both output enable and write enable low, has passed.
- R9: A write of 1 by a port that has a pending request but does not own the latch withdraws the request. A later release by the owner then leaves the latch free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_sel_i | input | 1 | Left semaphore select, active high |
| l_mem_ce_i | input | 1 | Left memory chip enable, active high; blocks semaphore access |
| l_we_i | input | 1 | Left write enable |
| l_oe_i | input | 1 | Left output (read) enable |
| l_idx_i | input | IDX_W (3) | Left latch index |
| l_wdata_i | input | 1 | Left write data: 0 requests, 1 releases |
| l_status_o | output | DATA_W (16) | Left read status, replicated on all bits (0 = owned by left) |
| r_sel_i | input | 1 | Right semaphore select, active high |
| r_mem_ce_i | input | 1 | Right memory chip enable, active high; blocks semaphore access |
| r_we_i | input | 1 | Right write enable |
| r_oe_i | input | 1 | Right output (read) enable |
| r_idx_i | input | IDX_W (3) | Right latch index |
| r_wdata_i | input | 1 | Right write data: 0 requests, 1 releases |
| r_status_o | output | DATA_W (16) | Right read status, replicated on all bits (0 = owned by right) |

## Verification
The bench targets the handover cases. A design that dropped a pending request would leave the waiting side reading 1 after the owner releases. A design that granted both sides in a tie would show zeros on both ports. The bench also checks withdrawal of a pending request: a design that forgot the withdrawal would hand the latch to a side that no longer wants it. The read-after-write case without a gap is driven on purpose. A design that refreshed the status at once would show the new grant early, and one that never cleared the stale condition would keep showing the old grant after a gap on either select or output enable. Accesses made with the memory chip enable high are checked to leave ownership and status untouched.

// File: rtl/sem_bank_pkg.sv
package sem_bank_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } sem_owner_e;

  localparam int unsigned PORT_L = 0;
  localparam int unsigned PORT_R = 1;
endpackage

// File: rtl/sem_cell.sv
module sem_cell
  import sem_bank_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_l_i,
  input  logic clr_l_i,
  input  logic set_r_i,
  input  logic clr_r_i,
  output logic own_l_o,
  output logic own_r_o,
  output logic req_l_o,
  output logic req_r_o
);
  sem_owner_e owner_q, owner_d;
  logic req_l_q, req_r_q, req_l_d, req_r_d;

  always_comb begin
    req_l_d = set_l_i ? 1'b1 : (clr_l_i ? 1'b0 : req_l_q);
    req_r_d = set_r_i ? 1'b1 : (clr_r_i ? 1'b0 : req_r_q);
    unique case (owner_q)
      OWN_LEFT:  owner_d = req_l_d ? OWN_LEFT  : (req_r_d ? OWN_RIGHT : OWN_NONE);
      OWN_RIGHT: owner_d = req_r_d ? OWN_RIGHT : (req_l_d ? OWN_LEFT  : OWN_NONE);
      default:   owner_d = req_l_d ? OWN_LEFT  : (req_r_d ? OWN_RIGHT : OWN_NONE); // tie -> left
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q <= OWN_NONE;
      req_l_q <= 1'b0;
      req_r_q <= 1'b0;
    end else begin
      owner_q <= owner_d;
      req_l_q <= req_l_d;
      req_r_q <= req_r_d;
    end
  end

  assign own_l_o = (owner_q == OWN_LEFT);
  assign own_r_o = (owner_q == OWN_RIGHT);
  assign req_l_o = req_l_q;
  assign req_r_o = req_r_q;
endmodule

// File: rtl/sem_port.sv
module sem_port #(
  parameter int unsigned NUM_SEM = 8,
  parameter int unsigned DATA_W  = 16,
  localparam int unsigned IDX_W  = $clog2(NUM_SEM)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sel_i,
  input  logic               mem_ce_i,
  input  logic               we_i,
  input  logic               oe_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic               wdata_i,
  input  logic [NUM_SEM-1:0] owned_i,
  output logic [NUM_SEM-1:0] set_o,
  output logic [NUM_SEM-1:0] clr_o,
  output logic [DATA_W-1:0]  status_o
);
  logic acc, wr, rd, gap;
  logic stale_q, rd_q;
  logic [NUM_SEM-1:0] hit;

  assign acc = sel_i && !mem_ce_i;
  assign wr  = acc && we_i;
  assign rd  = acc && oe_i && !we_i;
  assign gap = !(acc && (oe_i || we_i));

  always_comb begin
    hit = '0;
    hit[idx_i] = 1'b1;
  end

  assign set_o = (wr && !wdata_i) ? hit : '0;
  assign clr_o = (wr &&  wdata_i) ? hit : '0;

  // status refreshes only once a gap has followed the last write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stale_q <= 1'b0;
      rd_q    <= 1'b1;
    end else begin
      if (wr)       stale_q <= 1'b1;
      else if (gap) stale_q <= 1'b0;
      if (rd && !stale_q) rd_q <= !owned_i[idx_i];
    end
  end

  assign status_o = {DATA_W{rd_q}};
endmodule

// File: rtl/sem_bank.sv
module sem_bank
  import sem_bank_pkg::*;
#(
  parameter int unsigned NUM_SEM = 8,
  parameter int unsigned DATA_W  = 16,
  localparam int unsigned IDX_W  = $clog2(NUM_SEM)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_sel_i,
  input  logic              l_mem_ce_i,
  input  logic              l_we_i,
  input  logic              l_oe_i,
  input  logic [IDX_W-1:0]  l_idx_i,
  input  logic              l_wdata_i,
  output logic [DATA_W-1:0] l_status_o,
  input  logic              r_sel_i,
  input  logic              r_mem_ce_i,
  input  logic              r_we_i,
  input  logic              r_oe_i,
  input  logic [IDX_W-1:0]  r_idx_i,
  input  logic              r_wdata_i,
  output logic [DATA_W-1:0] r_status_o
);
  logic [1:0]              sel_v, ce_v, we_v, oe_v, wd_v;
  logic [1:0][IDX_W-1:0]   idx_v;
  logic [1:0][NUM_SEM-1:0] own_v, set_v, clr_v;
  logic [1:0][DATA_W-1:0]  stat_v;
  logic [NUM_SEM-1:0]      own_l, own_r, req_l, req_r;

  assign sel_v = {r_sel_i,    l_sel_i};
  assign ce_v  = {r_mem_ce_i, l_mem_ce_i};
  assign we_v  = {r_we_i,     l_we_i};
  assign oe_v  = {r_oe_i,     l_oe_i};
  assign wd_v  = {r_wdata_i,  l_wdata_i};
  assign idx_v = {r_idx_i,    l_idx_i};
  assign own_v = {own_r,      own_l};

  for (genvar p = 0; p < 2; p++) begin : g_port
    sem_port #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_port (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sel_i    (sel_v[p]),
      .mem_ce_i (ce_v[p]),
      .we_i     (we_v[p]),
      .oe_i     (oe_v[p]),
      .idx_i    (idx_v[p]),
      .wdata_i  (wd_v[p]),
      .owned_i  (own_v[p]),
      .set_o    (set_v[p]),
      .clr_o    (clr_v[p]),
      .status_o (stat_v[p])
    );
  end

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_cell
    sem_cell u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_l_i (set_v[PORT_L][i]),
      .clr_l_i (clr_v[PORT_L][i]),
      .set_r_i (set_v[PORT_R][i]),
      .clr_r_i (clr_v[PORT_R][i]),
      .own_l_o (own_l[i]),
      .own_r_o (own_r[i]),
      .req_l_o (req_l[i]),
      .req_r_o (req_r[i])
    );
  end

  assign l_status_o = stat_v[PORT_L];
  assign r_status_o = stat_v[PORT_R];
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
  parameter int unsigned NUM_SEM = 8,
  parameter int unsigned DATA_W  = 16,
  localparam int unsigned IDX_W  = $clog2(NUM_SEM)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               l_sel_i,
  input logic               l_mem_ce_i,
  input logic               l_we_i,
  input logic               l_oe_i,
  input logic [IDX_W-1:0]   l_idx_i,
  input logic               l_wdata_i,
  input logic [DATA_W-1:0]  l_status_o,
  input logic               r_sel_i,
  input logic               r_mem_ce_i,
  input logic               r_we_i,
  input logic [IDX_W-1:0]   r_idx_i,
  input logic               r_wdata_i,
  input logic [NUM_SEM-1:0] own_l,
  input logic [NUM_SEM-1:0] own_r,
  input logic [NUM_SEM-1:0] req_l,
  input logic [NUM_SEM-1:0] req_r
);
  logic l_acc, r_acc, l_wr, l_rd;
  assign l_acc = l_sel_i && !l_mem_ce_i;
  assign r_acc = r_sel_i && !r_mem_ce_i;
  assign l_wr  = l_acc && l_we_i;
  assign l_rd  = l_acc && l_oe_i && !l_we_i;

  p_no_access_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!l_acc && !r_acc) |=> ($stable(own_l) && $stable(own_r)));

  p_stale_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_rd && $past(l_wr)) |=> $stable(l_status_o));

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_chk
    p_owner_requested_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (own_l[i] |-> req_l[i]) and (own_r[i] |-> req_r[i]));

    p_handover_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(own_l[i]) && req_r[i]) |-> own_r[i]);

    p_tie_left_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!own_l[i] && !own_r[i]
       && l_acc && l_we_i && !l_wdata_i && l_idx_i == IDX_W'(i)
       && r_acc && r_we_i && !r_wdata_i && r_idx_i == IDX_W'(i))
      |=> (own_l[i] && req_r[i]));
  end
endmodule

bind sem_bank sem_bank_chk #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_sem_bank_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .l_sel_i    (l_sel_i),
  .l_mem_ce_i (l_mem_ce_i),
  .l_we_i     (l_we_i),
  .l_oe_i     (l_oe_i),
  .l_idx_i    (l_idx_i),
  .l_wdata_i  (l_wdata_i),
  .l_status_o (l_status_o),
  .r_sel_i    (r_sel_i),
  .r_mem_ce_i (r_mem_ce_i),
  .r_we_i     (r_we_i),
  .r_idx_i    (r_idx_i),
  .r_wdata_i  (r_wdata_i),
  .own_l      (own_l),
  .own_r      (own_r),
  .req_l      (req_l),
  .req_r      (req_r)
);

// File: tb/sem_bank_test.sv
module sem_bank_test;
  localparam int unsigned NUM_SEM = 8;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned IDX_W   = $clog2(NUM_SEM);
  localparam logic [DATA_W-1:0] ONES  = '1;
  localparam logic [DATA_W-1:0] ZEROS = '0;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic l_sel, l_ce, l_we, l_oe, l_wd, r_sel, r_ce, r_we, r_oe, r_wd;
  logic [IDX_W-1:0] l_idx, r_idx;
  logic [DATA_W-1:0] l_stat, r_stat;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sem_bank #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .l_sel_i(l_sel), .l_mem_ce_i(l_ce), .l_we_i(l_we), .l_oe_i(l_oe),
    .l_idx_i(l_idx), .l_wdata_i(l_wd), .l_status_o(l_stat),
    .r_sel_i(r_sel), .r_mem_ce_i(r_ce), .r_we_i(r_we), .r_oe_i(r_oe),
    .r_idx_i(r_idx), .r_wdata_i(r_wd), .r_status_o(r_stat)
  );

  task automatic chk(input string tag, input logic [DATA_W-1:0] got, exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input bit p, input logic sel, ce, we, oe,
                       input int idx, input logic d);
    if (p == 0) begin
      l_sel = sel; l_ce = ce; l_we = we; l_oe = oe; l_idx = IDX_W'(idx); l_wd = d;
    end else begin
      r_sel = sel; r_ce = ce; r_we = we; r_oe = oe; r_idx = IDX_W'(idx); r_wd = d;
    end
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 1);
    drive(1, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic sem_wr(input bit p, input int idx, input logic d);
    drive(p, 1, 0, 1, 0, idx, d);
    tick();
    idle();
    tick();
  endtask

  task automatic sem_rd(input bit p, input int idx, input logic [DATA_W-1:0] exp,
                        input string tag);
    drive(p, 1, 0, 0, 1, idx, 1);
    tick();
    idle();
    chk(tag, (p == 0) ? l_stat : r_stat, exp);
    tick();
  endtask

  task automatic t_reset();
    chk("R1 left status out of reset", l_stat, ONES);
    chk("R1 right status out of reset", r_stat, ONES);
    for (int i = 0; i < NUM_SEM; i++) begin
      sem_rd(0, i, ONES, "R1 left read after reset");
      sem_rd(1, i, ONES, "R1 right read after reset");
    end
  endtask

  task automatic t_claim_release();
    sem_wr(0, 3, 0);
    sem_rd(0, 3, ZEROS, "R2 left owns idx3");
    sem_rd(1, 3, ONES, "R2 right sees idx3 taken");
    sem_wr(0, 3, 1);
    sem_rd(0, 3, ONES, "R3 left released idx3");
    sem_rd(1, 3, ONES, "R3 right sees idx3 free");
  endtask

  task automatic t_handover();
    sem_wr(1, 5, 0);
    sem_wr(0, 5, 0);
    sem_rd(0, 5, ONES, "R4 left pending reads one");
    sem_rd(1, 5, ZEROS, "R4 right still owns");
    sem_wr(1, 5, 1);
    sem_rd(0, 5, ZEROS, "R4 left granted on release");
    sem_rd(1, 5, ONES, "R4 right after handover");
    sem_wr(0, 5, 1);
    sem_rd(1, 5, ONES, "R3 idx5 free after final release");
  endtask

  task automatic t_tie();
    drive(0, 1, 0, 1, 0, 1, 0);
    drive(1, 1, 0, 1, 0, 1, 0);
    tick();
    idle();
    tick();
    sem_rd(0, 1, ZEROS, "R5 left wins tie");
    sem_rd(1, 1, ONES, "R5 right loses tie");
    sem_wr(0, 1, 1);
    sem_rd(1, 1, ZEROS, "R5 right pending granted");
    sem_wr(1, 1, 1);
  endtask

  task automatic t_indep();
    sem_wr(0, 0, 0);
    sem_wr(1, 7, 0);
    sem_rd(0, 0, ZEROS, "R6 left owns idx0");
    sem_rd(1, 7, ZEROS, "R6 right owns idx7");
    sem_rd(0, 7, ONES, "R6 left idx7");
    sem_rd(1, 0, ONES, "R6 right idx0");
    sem_rd(0, 2, ONES, "R6 left untouched idx2");
    sem_rd(1, 2, ONES, "R6 right untouched idx2");
    sem_wr(0, 0, 1);
    sem_rd(1, 7, ZEROS, "R6 idx7 unaffected by idx0 release");
    sem_wr(1, 7, 1);
  endtask

  task automatic t_chip_enable();
    drive(0, 1, 1, 1, 0, 2, 0);
    tick();
    idle();
    tick();
    sem_rd(0, 2, ONES, "R7 write with mem enable ignored");
    sem_rd(1, 2, ONES, "R7 right sees idx2 free");
    drive(1, 0, 0, 1, 0, 2, 0);
    tick();
    idle();
    tick();
    sem_rd(1, 2, ONES, "R7 write without select ignored");
    sem_wr(0, 2, 0);
    sem_rd(0, 4, ONES, "R7 left status primed to one");
    drive(0, 1, 1, 0, 1, 2, 1);
    tick();
    idle();
    chk("R7 read with mem enable leaves status", l_stat, ONES);
    tick();
    sem_wr(0, 2, 1);
  endtask

  task automatic t_stale();
    sem_rd(0, 6, ONES, "R8 prime status");
    drive(0, 1, 0, 1, 0, 6, 0);
    tick();
    drive(0, 1, 0, 0, 1, 6, 1);
    tick();
    chk("R8 read right after write stale", l_stat, ONES);
    tick();
    chk("R8 continued read still stale", l_stat, ONES);
    drive(0, 1, 0, 0, 0, 6, 1);
    tick();
    drive(0, 1, 0, 0, 1, 6, 1);
    tick();
    chk("R8 read after enable gap fresh", l_stat, ZEROS);
    drive(0, 1, 0, 1, 0, 6, 1);
    tick();
    drive(0, 1, 0, 0, 1, 6, 1);
    tick();
    chk("R8 stale after release", l_stat, ZEROS);
    idle();
    tick();
    sem_rd(0, 6, ONES, "R8 read after select gap fresh");
  endtask

  task automatic t_withdraw();
    sem_wr(0, 4, 0);
    sem_wr(1, 4, 0);
    sem_wr(1, 4, 1);
    sem_wr(0, 4, 1);
    sem_rd(1, 4, ONES, "R9 withdrawn request not granted");
    sem_rd(0, 4, ONES, "R9 latch free after withdraw");
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_claim_release();
    t_handover();
    t_tie();
    t_indep();
    t_chip_enable();
    t_stale();
    t_withdraw();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule